// File: doc/BRIEF.md
# Scanline Interrupt and Blanking Controller

This block keeps the vertical position of a raster display and turns that position into the interrupt traffic a CPU needs. Every end-of-line strobe advances a line counter that wraps at a frame length chosen by a 50/60 Hz style select. Lines derived from a programmable visible height mark the start and the end of vertical blanking and a controller-poll line. A vertical-blank NMI is raised when enabled. If the CPU is halted in a wait instruction, the NMI is raised at once and the CPU is woken. Otherwise the NMI passes through two delay stages that advance on instruction-step strobes.

Two beam-position IRQ sources sit beside the NMI path. The vertical source fires when a new line matches a compare value while only the vertical timer is enabled. The horizontal source fires on a horizontal-timer match strobe, and it is qualified by the line compare whenever the vertical timer is enabled. The sources are kept in a sticky mask that per-bit acknowledges clear. A single IRQ request line is gated by a global disable. Raising any interrupt while the CPU waits produces a one-cycle wake pulse.

Top module: `scanline_irq_ctrl`

## Requirements
- R1: Each cycle with `line_end_i` high moves `line_o` to the next line on the following edge. After line 261 (`pal_i`=0) or line 311 (`pal_i`=1) the next line is 0, and `frame_o` is high for exactly the one cycle in which `line_o` first shows 0.
- R2: `vblank_o` becomes 8'h80 when `line_o` becomes `height_i`+1. It becomes 8'h00 when `line_o` becomes 1. It holds its value on every other line.
- R3: `joy_o` is high for the one cycle after `line_o` becomes `height_i`+3, and low otherwise.
- R4: When vertical blanking starts with `nmi_en_i` high and `cpu_wait_i` high, `nmi_o` and `wake_o` rise on that same edge.
- R5: When vertical blanking starts with `nmi_en_i` high and `cpu_wait_i` low, `nmi_o` rises on the edge of the second `step_i` strobe after the vblank-start cycle. A `step_i` in the vblank-start cycle itself does not count.
- R6: With `nmi_en_i` low, vertical-blank start leaves `nmi_o` low.
- R7: Bit 0 of `irq_src_o` (vertical source) is set when `line_o` becomes `vcmp_i` while `vtimer_en_i` is high and `htimer_en_i` is low. With both enables high, no such set occurs.
- R8: Bit 1 of `irq_src_o` (horizontal source) is set on an `htimer_i` strobe when `vtimer_en_i` is low, or when `line_o` as it stood before that edge equals `vcmp_i`.
- R9: `wake_o` pulses for one cycle when an IRQ source is set while `cpu_wait_i` is high. It stays low when a source is set with `cpu_wait_i` low.
- R10: `irq_o` is high exactly when `irq_src_o` is non-zero and `irq_dis_i` is low.
- R11: An `irq_ack_i` bit clears the matching `irq_src_o` bit, and `nmi_ack_i` clears `nmi_o`. A set in the same cycle wins over the acknowledge.
- R12: While `rst_ni` is low, every output is 0, including `line_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| line_end_i | input | 1 | End-of-line strobe |
| htimer_i | input | 1 | Horizontal-timer match strobe |
| step_i | input | 1 | Instruction-step strobe, advances the NMI delay |
| pal_i | input | 1 | Selects the long (312-line) frame |
| height_i | input | 9 | Visible screen height in lines |
| vcmp_i | input | 9 | Line compare value for the beam IRQs |
| htimer_en_i | input | 1 | Horizontal timer enable |
| vtimer_en_i | input | 1 | Vertical timer enable |
| nmi_en_i | input | 1 | Vertical-blank NMI enable |
| cpu_wait_i | input | 1 | CPU is halted waiting for an interrupt |
| irq_dis_i | input | 1 | Global IRQ disable |
| irq_ack_i | input | 2 | Per-source IRQ acknowledge |
| nmi_ack_i | input | 1 | NMI acknowledge |
| line_o | output | 9 | Current line |
| vblank_o | output | 8 | Blanking status, 8'h80 in blanking |
| nmi_o | output | 1 | Latched NMI request |
| irq_src_o | output | 2 | IRQ source mask: bit 0 vertical, bit 1 horizontal |
| irq_o | output | 1 | IRQ request |
| wake_o | output | 1 | One-cycle CPU wake pulse |
| frame_o | output | 1 | Frame-start pulse |
| joy_o | output | 1 | Controller-poll pulse |

## Verification
Several functions can fall on the same edge. The sharpest cases are vblank start together with an instruction step, and a horizontal-timer strobe together with an end-of-line strobe. The bench drives `step_i` in the vblank-start cycle and expects the NMI only after two further steps. It also drives `htimer_i` and `line_end_i` together. There it expects the horizontal qualification to use the old line while the vertical source compares the new one, so one line yields mask 2 and the next yields mask 1. A set arriving with its own acknowledge is also provoked, and the set must win.

// File: rtl/sl_irq_pkg.sv
package sl_irq_pkg;
  localparam int NSRC     = 2;
  localparam int SRC_V    = 0;
  localparam int SRC_H    = 1;
  localparam logic [7:0] VBL_ON = 8'h80;
endpackage

// File: rtl/sl_line_ctr.sv
module sl_line_ctr #(
  parameter int LINE_W   = 9,
  parameter int MAX_NTSC = 261,
  parameter int MAX_PAL  = 311
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              adv_i,
  input  logic              pal_i,
  output logic [LINE_W-1:0] line_o,
  output logic [LINE_W-1:0] line_nxt_o,
  output logic              frame_o
);
  logic [LINE_W-1:0] line_q, max_line;
  logic              wrap;
  logic              frame_q;

  assign max_line   = pal_i ? LINE_W'(MAX_PAL) : LINE_W'(MAX_NTSC);
  assign wrap       = (line_q >= max_line);
  assign line_nxt_o = wrap ? '0 : line_q + 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      line_q  <= '0;
      frame_q <= 1'b0;
    end else begin
      if (adv_i) line_q <= line_nxt_o;
      frame_q <= adv_i & wrap;
    end
  end

  assign line_o  = line_q;
  assign frame_o = frame_q;
endmodule

// File: rtl/sl_vbl_ctl.sv
module sl_vbl_ctl
  import sl_irq_pkg::*;
#(
  parameter int LINE_W     = 9,
  parameter int FIRST_LINE = 1,
  parameter int JOY_OFS    = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              adv_i,
  input  logic [LINE_W-1:0] line_nxt_i,
  input  logic [LINE_W-1:0] height_i,
  output logic              vbl_start_o,
  output logic [7:0]        vblank_o,
  output logic              joy_o
);
  localparam int EW = LINE_W + 1;
  logic [EW-1:0] nxt_ext, vbl_line, joy_line, vis_line;
  logic          vbl_end, joy_hit;
  logic [7:0]    vbl_q;
  logic          joy_q;

  assign nxt_ext  = {1'b0, line_nxt_i};
  assign vbl_line = {1'b0, height_i} + EW'(FIRST_LINE);
  assign joy_line = {1'b0, height_i} + EW'(JOY_OFS);
  assign vis_line = EW'(FIRST_LINE);

  assign vbl_start_o = adv_i & (nxt_ext == vbl_line);
  assign vbl_end     = adv_i & (nxt_ext == vis_line);
  assign joy_hit     = adv_i & (nxt_ext == joy_line);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vbl_q <= '0;
      joy_q <= 1'b0;
    end else begin
      if (vbl_start_o)  vbl_q <= VBL_ON;
      else if (vbl_end) vbl_q <= '0;
      joy_q <= joy_hit;
    end
  end

  assign vblank_o = vbl_q;
  assign joy_o    = joy_q;
endmodule

// File: rtl/sl_nmi_pipe.sv
module sl_nmi_pipe (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic vbl_start_i,
  input  logic nmi_en_i,
  input  logic cpu_wait_i,
  input  logic step_i,
  input  logic ack_i,
  output logic nmi_now_o,
  output logic nmi_o
);
  logic fire, dly1_q, dly2_q, nmi_q;

  assign fire      = vbl_start_i & nmi_en_i;
  assign nmi_now_o = fire & cpu_wait_i;

  // Stage 2 promotes before stage 1 advances; a new fire refills stage 1.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dly1_q <= 1'b0;
      dly2_q <= 1'b0;
      nmi_q  <= 1'b0;
    end else begin
      dly1_q <= (fire & ~cpu_wait_i) | (dly1_q & ~step_i);
      if (step_i) dly2_q <= dly1_q;
      nmi_q  <= nmi_now_o | (step_i & dly2_q) | (nmi_q & ~ack_i);
    end
  end

  assign nmi_o = nmi_q;
endmodule

// File: rtl/sl_irq_src.sv
module sl_irq_src
  import sl_irq_pkg::*;
#(
  parameter int LINE_W = 9
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              adv_i,
  input  logic              htimer_i,
  input  logic [LINE_W-1:0] line_i,
  input  logic [LINE_W-1:0] line_nxt_i,
  input  logic [LINE_W-1:0] vcmp_i,
  input  logic              hen_i,
  input  logic              ven_i,
  input  logic              dis_i,
  input  logic [NSRC-1:0]   ack_i,
  output logic [NSRC-1:0]   src_o,
  output logic              raise_o,
  output logic              irq_o
);
  logic [NSRC-1:0] set, src_q;

  assign set[SRC_V] = adv_i & ven_i & ~hen_i & (line_nxt_i == vcmp_i);
  assign set[SRC_H] = htimer_i & (~ven_i | (line_i == vcmp_i));

  for (genvar g = 0; g < NSRC; g++) begin : g_src
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) src_q[g] <= 1'b0;
      else         src_q[g] <= set[g] | (src_q[g] & ~ack_i[g]);
    end
  end

  assign src_o   = src_q;
  assign raise_o = |set;
  assign irq_o   = (|src_q) & ~dis_i;
endmodule

// File: rtl/scanline_irq_ctrl.sv
module scanline_irq_ctrl
  import sl_irq_pkg::*;
#(
  parameter int LINE_W     = 9,
  parameter int MAX_NTSC   = 261,
  parameter int MAX_PAL    = 311,
  parameter int FIRST_LINE = 1,
  parameter int JOY_OFS    = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              line_end_i,
  input  logic              htimer_i,
  input  logic              step_i,
  input  logic              pal_i,
  input  logic [LINE_W-1:0] height_i,
  input  logic [LINE_W-1:0] vcmp_i,
  input  logic              htimer_en_i,
  input  logic              vtimer_en_i,
  input  logic              nmi_en_i,
  input  logic              cpu_wait_i,
  input  logic              irq_dis_i,
  input  logic [NSRC-1:0]   irq_ack_i,
  input  logic              nmi_ack_i,
  output logic [LINE_W-1:0] line_o,
  output logic [7:0]        vblank_o,
  output logic              nmi_o,
  output logic [NSRC-1:0]   irq_src_o,
  output logic              irq_o,
  output logic              wake_o,
  output logic              frame_o,
  output logic              joy_o
);
  logic [LINE_W-1:0] line_nxt;
  logic              vbl_start, nmi_now, irq_raise, wake_q;

  sl_line_ctr #(.LINE_W(LINE_W), .MAX_NTSC(MAX_NTSC), .MAX_PAL(MAX_PAL)) u_line (
    .clk_i, .rst_ni, .adv_i(line_end_i), .pal_i,
    .line_o, .line_nxt_o(line_nxt), .frame_o
  );

  sl_vbl_ctl #(.LINE_W(LINE_W), .FIRST_LINE(FIRST_LINE), .JOY_OFS(JOY_OFS)) u_vbl (
    .clk_i, .rst_ni, .adv_i(line_end_i), .line_nxt_i(line_nxt), .height_i,
    .vbl_start_o(vbl_start), .vblank_o, .joy_o
  );

  sl_nmi_pipe u_nmi (
    .clk_i, .rst_ni, .vbl_start_i(vbl_start), .nmi_en_i, .cpu_wait_i,
    .step_i, .ack_i(nmi_ack_i), .nmi_now_o(nmi_now), .nmi_o
  );

  sl_irq_src #(.LINE_W(LINE_W)) u_irq (
    .clk_i, .rst_ni, .adv_i(line_end_i), .htimer_i, .line_i(line_o),
    .line_nxt_i(line_nxt), .vcmp_i, .hen_i(htimer_en_i), .ven_i(vtimer_en_i),
    .dis_i(irq_dis_i), .ack_i(irq_ack_i), .src_o(irq_src_o),
    .raise_o(irq_raise), .irq_o
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) wake_q <= 1'b0;
    else         wake_q <= cpu_wait_i & (nmi_now | irq_raise);
  end

  assign wake_o = wake_q;
endmodule

// File: rtl/sl_irq_chk.sv
module sl_irq_chk #(
  parameter int LINE_W = 9
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              line_end_i,
  input logic              cpu_wait_i,
  input logic              irq_dis_i,
  input logic [LINE_W-1:0] line_o,
  input logic [7:0]        vblank_o,
  input logic              irq_o,
  input logic              wake_o,
  input logic              frame_o,
  input logic              joy_o
);
  a_r1_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    line_end_i |=> (line_o == $past(line_o) + 1'b1) || (line_o == '0));
  a_r1_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !line_end_i |=> $stable(line_o));
  a_r1_frame: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_o |-> (line_o == '0));
  a_r2_code: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vblank_o == 8'h00) || (vblank_o == 8'h80));
  a_r3_joy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    joy_o |-> $past(line_end_i));
  a_r9_wake: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wake_o |-> $past(cpu_wait_i));
  a_r10_dis: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_dis_i |-> !irq_o);
endmodule

bind scanline_irq_ctrl sl_irq_chk #(.LINE_W(LINE_W)) u_chk (
  .clk_i, .rst_ni, .line_end_i, .cpu_wait_i, .irq_dis_i,
  .line_o, .vblank_o, .irq_o, .wake_o, .frame_o, .joy_o
);

// File: tb/scanline_irq_ctrl_tb.sv
module scanline_irq_ctrl_tb;
  localparam int CLK_PERIOD = 10;

  logic       clk_i = 1'b0, rst_ni = 1'b0;
  logic       line_end_i = 0, htimer_i = 0, step_i = 0, pal_i = 0;
  logic [8:0] height_i = 9'd224, vcmp_i = '0;
  logic       htimer_en_i = 0, vtimer_en_i = 0, nmi_en_i = 0, cpu_wait_i = 0;
  logic       irq_dis_i = 0, nmi_ack_i = 0;
  logic [1:0] irq_ack_i = '0;
  logic [8:0] line_o;
  logic [7:0] vblank_o;
  logic       nmi_o, irq_o, wake_o, frame_o, joy_o;
  logic [1:0] irq_src_o;

  scanline_irq_ctrl u_dut (
    .clk_i, .rst_ni, .line_end_i, .htimer_i, .step_i, .pal_i, .height_i,
    .vcmp_i, .htimer_en_i, .vtimer_en_i, .nmi_en_i, .cpu_wait_i, .irq_dis_i,
    .irq_ack_i, .nmi_ack_i, .line_o, .vblank_o, .nmi_o, .irq_src_o, .irq_o,
    .wake_o, .frame_o, .joy_o
  );

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  typedef enum int {S_LINE, S_VBL, S_NMI, S_SRC, S_IRQ, S_WAKE, S_FRAME, S_JOY} sig_e;
  typedef struct { string req; sig_e sig; int val; } item_t;

  item_t q[$];
  int    n_chk = 0, n_fail = 0;
  int    exp_line = 0;
  bit    done = 0;

  function automatic int get_val(sig_e s);
    case (s)
      S_LINE:  return int'(line_o);
      S_VBL:   return int'(vblank_o);
      S_NMI:   return int'(nmi_o);
      S_SRC:   return int'(irq_src_o);
      S_IRQ:   return int'(irq_o);
      S_WAKE:  return int'(wake_o);
      S_FRAME: return int'(frame_o);
      default: return int'(joy_o);
    endcase
  endfunction

  // monitor
  always @(negedge clk_i) begin
    while (q.size() > 0) begin
      item_t it;
      int    got;
      it  = q.pop_front();
      got = get_val(it.sig);
      n_chk++;
      if (got != it.val) begin
        n_fail++;
        $display("FAIL %s %s got %0d expected %0d", it.req, it.sig.name(), got, it.val);
      end
    end
  end

  task automatic expect_v(string r, sig_e s, int v);
    q.push_back('{r, s, v});
  endtask

  task automatic flush();
    @(negedge clk_i); #1;
  endtask

  task automatic step_clk();
    @(posedge clk_i); #1;
    if (line_end_i) exp_line = (exp_line >= (pal_i ? 311 : 261)) ? 0 : exp_line + 1;
    line_end_i = 0; htimer_i = 0; step_i = 0; irq_ack_i = '0; nmi_ack_i = 0;
  endtask

  task automatic adv();
    line_end_i = 1;
    step_clk();
  endtask

  task automatic adv_to(int t);
    while (exp_line != t) adv();
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    // R12 reset
    repeat (3) @(posedge clk_i);
    #1;
    expect_v("R12", S_LINE, 0);  expect_v("R12", S_VBL, 0);  expect_v("R12", S_NMI, 0);
    expect_v("R12", S_SRC, 0);   expect_v("R12", S_IRQ, 0);  expect_v("R12", S_WAKE, 0);
    expect_v("R12", S_FRAME, 0); expect_v("R12", S_JOY, 0);
    flush();
    rst_ni = 1;
    flush();

    // R1 R2 R3 R6: one short frame, NMI disabled
    for (int i = 1; i <= 262; i++) begin
      adv();
      case (exp_line)
        1:   begin expect_v("R1", S_LINE, 1); expect_v("R2", S_VBL, 0); end
        224: expect_v("R2", S_VBL, 0);
        225: begin expect_v("R2", S_VBL, 128); expect_v("R6", S_NMI, 0); end
        226: expect_v("R3", S_JOY, 0);
        227: expect_v("R3", S_JOY, 1);
        228: begin expect_v("R3", S_JOY, 0); expect_v("R2", S_VBL, 128); end
        261: expect_v("R1", S_FRAME, 0);
        0:   begin expect_v("R1", S_LINE, 0); expect_v("R1", S_FRAME, 1); end
        default: ;
      endcase
      if (q.size() > 0) flush();
    end
    adv();
    expect_v("R1", S_FRAME, 0); expect_v("R2", S_VBL, 0); expect_v("R1", S_LINE, 1);
    flush();

    // R1 long frame
    pal_i = 1;
    adv_to(261); adv();
    expect_v("R1", S_LINE, 262); expect_v("R1", S_FRAME, 0); flush();
    adv_to(311); adv();
    expect_v("R1", S_LINE, 0); expect_v("R1", S_FRAME, 1); flush();
    pal_i = 0;
    adv();

    // R4 immediate NMI with wake
    nmi_en_i = 1; cpu_wait_i = 1;
    adv_to(224); adv();
    expect_v("R4", S_NMI, 1); expect_v("R4", S_WAKE, 1); expect_v("R2", S_VBL, 128); flush();
    step_clk();
    expect_v("R9", S_WAKE, 0); expect_v("R4", S_NMI, 1); flush();
    nmi_ack_i = 1; step_clk();
    expect_v("R11", S_NMI, 0); flush();

    // R5 delayed NMI
    cpu_wait_i = 0;
    adv_to(224); adv();
    expect_v("R5", S_NMI, 0); expect_v("R5", S_WAKE, 0); flush();
    step_i = 1; step_clk();
    expect_v("R5", S_NMI, 0); flush();
    step_i = 1; step_clk();
    expect_v("R5", S_NMI, 1); flush();
    nmi_ack_i = 1; step_clk();
    expect_v("R11", S_NMI, 0); flush();

    // R5 step in the vblank-start cycle does not count
    adv_to(224);
    step_i = 1; adv();
    expect_v("R5", S_NMI, 0); flush();
    step_i = 1; step_clk();
    expect_v("R5", S_NMI, 0); flush();
    step_i = 1; step_clk();
    expect_v("R5", S_NMI, 1); flush();
    nmi_ack_i = 1; step_clk();
    expect_v("R11", S_NMI, 0); flush();

    // R11 NMI set wins over ack
    cpu_wait_i = 1;
    adv_to(224);
    nmi_ack_i = 1; adv();
    expect_v("R11", S_NMI, 1); flush();
    nmi_ack_i = 1; step_clk();
    expect_v("R11", S_NMI, 0); flush();
    nmi_en_i = 0;

    // R7 R9 R10 vertical source
    vcmp_i = 9'd230; vtimer_en_i = 1; htimer_en_i = 0; cpu_wait_i = 1;
    adv_to(229); adv();
    expect_v("R7", S_SRC, 1); expect_v("R10", S_IRQ, 1); expect_v("R9", S_WAKE, 1); flush();
    irq_dis_i = 1;
    expect_v("R10", S_IRQ, 0); expect_v("R7", S_SRC, 1); flush();
    irq_dis_i = 0;
    irq_ack_i = 2'b01; step_clk();
    expect_v("R11", S_SRC, 0); expect_v("R10", S_IRQ, 0); flush();
    cpu_wait_i = 0;

    // R7 both enables: no vertical set
    htimer_en_i = 1; vcmp_i = 9'd231;
    adv();
    expect_v("R7", S_SRC, 0); flush();

    // R8 horizontal source qualified by line
    htimer_i = 1; step_clk();
    expect_v("R8", S_SRC, 2); expect_v("R9", S_WAKE, 0); flush();
    irq_ack_i = 2'b10; step_clk();
    expect_v("R11", S_SRC, 0); flush();
    vcmp_i = 9'd100;
    htimer_i = 1; step_clk();
    expect_v("R8", S_SRC, 0); flush();
    vtimer_en_i = 0;
    htimer_i = 1; step_clk();
    expect_v("R8", S_SRC, 2); flush();
    htimer_i = 1; irq_ack_i = 2'b10; step_clk();
    expect_v("R11", S_SRC, 2); flush();
    irq_ack_i = 2'b10; step_clk();
    expect_v("R11", S_SRC, 0); flush();

    // R8 same-cycle H strobe and line end: old line qualifies
    vtimer_en_i = 1; vcmp_i = 9'd231;
    htimer_i = 1; adv();
    expect_v("R8", S_LINE, 232); expect_v("R8", S_SRC, 2); flush();
    irq_ack_i = 2'b10; step_clk();
    flush();

    // R7 R8 same cycle: vertical matches new line, horizontal sees old
    htimer_en_i = 0; vcmp_i = 9'd233;
    htimer_i = 1; adv();
    expect_v("R7", S_SRC, 1); flush();

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule